// File: doc/BRIEF.md
# Addressed Serial Segment-Data Receiver

This block is the input side of a four-way multiplexed segment display driver with 128 segments. A host sends display data over a two-wire link made of a data line and a clock line. A third line, an enable strobe, is optional. Several receivers and other peripherals can sit on the same lines. Each receiver answers only to the 8-bit address strapped on its `dev_addr_i` pins.

A frame has four parts in this order: a start condition, an address byte, 128 payload bits, and then either a stop condition or an enable pulse, which commits the payload. Each payload bit drives one segment directly. No character decoding is done, so the host does all segment formatting. When a complete frame addressed to this receiver is committed, the 128 bits are copied into a display latch and a one-cycle update strobe is raised.

The serial pins are asynchronous to the system clock. They pass through synchroniser flops, and edges and bus conditions are detected from the synchronised copies. Each phase of the serial clock must last several system clock cycles.

Top module: `seg_frame_rx`

## Requirements
- R1: After reset, `seg_o` is all zeros and `seg_upd_o` is low.
- R2: A start condition is a fall of the data line while the clock line is high. The next 8 rising clock edges sample the address, most significant bit first. When this address equals `dev_addr_i`, the frame is accepted.
- R3: Payload bits are sampled on the rising edges of the clock. Arrival number k (counting from 0) lands in `seg_o[4*(k/4) + 3 - (k%4)]`. Bits therefore come in groups of four, one group per frontplane starting with the first. Within a group the backplanes come in the order 4, 3, 2, 1, so the first bit received lands in `seg_o[3]`.
- R4: When the address does not match, every bit up to the next start condition is ignored, and `seg_o` and `seg_upd_o` do not change.
- R5: A stop condition that arrives before all 128 payload bits discards the frame, and `seg_o` keeps its old value.
- R6: A stop condition is a rise of the data line while the clock line is high. A stop after all 128 payload bits loads `seg_o` and raises `seg_upd_o` for exactly one system cycle.
- R7: An enable rise while the clock line is high, after all 128 payload bits, commits the frame in the same way as a stop.
- R8: An enable pulse while the clock line is low has no effect. The frame stays pending and a later stop still commits it.
- R9: Clock edges after the 128th payload bit are ignored. The committed value holds the first 128 bits.
- R10: A start condition in the middle of a frame abandons that frame and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_addr_i | input | 8 | Strapped device address |
| sdat_i | input | 1 | Serial data line, asynchronous |
| sclk_i | input | 1 | Serial clock line, asynchronous |
| senb_i | input | 1 | Optional enable strobe, asynchronous |
| seg_o | output | 128 | Latched segment word |
| seg_upd_o | output | 1 | One-cycle strobe when `seg_o` is loaded |

## Verification
Any fault inside the block shows up at `seg_o` only when a frame commits. The exception is a wrong bit count, which can also show up as a missing or extra `seg_upd_o` pulse.

- A wrong frame state, such as taking a foreign address as a match, shows as a stray update after the commit condition.
- An off-by-one bit counter shows as payload shifted across frontplane groups.
- A mirrored index map shows as swapped backplanes within a group.

The bench therefore uses asymmetric patterns and a single-bit frame, and compares the whole latch a few system cycles after each commit.

// File: rtl/seg_rx_pkg.sv
package seg_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_FULL,
    ST_SKIP
  } rx_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic bit_stb;
    logic bit_val;
    logic enb_cmt;
  } pin_evt_t;

endpackage

// File: rtl/seg_pin_sync.sv
module seg_pin_sync
  import seg_rx_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sdat_i,
  input  logic     sclk_i,
  input  logic     senb_i,
  output pin_evt_t evt_o
);

  localparam int NPIN = 3;
  // idle levels of the bus: {enb, clk, dat}
  localparam logic [NPIN-1:0] IDLE_LVL = 3'b011;
  localparam int P_DAT = 0;
  localparam int P_CLK = 1;
  localparam int P_ENB = 2;

  logic [NPIN-1:0] raw, cur, prv;
  assign raw = {senb_i, sclk_i, sdat_i};

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= {STAGES{IDLE_LVL[p]}};
      else         chain <= {chain[STAGES-2:0], raw[p]};
    end
    assign cur[p] = chain[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prv <= IDLE_LVL;
    else         prv <= cur;
  end

  always_comb begin
    evt_o.start   = cur[P_CLK] & prv[P_CLK] &  prv[P_DAT] & ~cur[P_DAT];
    evt_o.stop    = cur[P_CLK] & prv[P_CLK] & ~prv[P_DAT] &  cur[P_DAT];
    evt_o.bit_stb = cur[P_CLK] & ~prv[P_CLK];
    evt_o.bit_val = cur[P_DAT];
    evt_o.enb_cmt = cur[P_ENB] & ~prv[P_ENB] & cur[P_CLK];
  end

endmodule

// File: rtl/seg_frame_ctrl.sv
module seg_frame_ctrl
  import seg_rx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SEG_W  = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  pin_evt_t          evt_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  output logic              shift_en_o,
  output logic              shift_bit_o,
  output logic              commit_o
);

  localparam int CNT_W = $clog2(SEG_W + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] SEG_LAST  = CNT_W'(SEG_W - 1);
  localparam logic [CNT_W-1:0] SEG_FULL  = CNT_W'(SEG_W);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_nxt;
  logic              addr_hit;

  assign addr_nxt    = {addr_q[ADDR_W-2:0], evt_i.bit_val};
  assign addr_hit    = (addr_nxt == dev_addr_i);
  assign shift_bit_o = evt_i.bit_val;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    addr_d     = addr_q;
    shift_en_o = 1'b0;
    commit_o   = 1'b0;
    if (evt_i.start) begin
      // restart from any state
      state_d = ST_ADDR;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (evt_i.stop) begin
            state_d = ST_IDLE;
          end else if (evt_i.bit_stb) begin
            addr_d = addr_nxt;
            if (cnt_q == ADDR_LAST) begin
              state_d = addr_hit ? ST_DATA : ST_SKIP;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (evt_i.stop) begin
            state_d = ST_IDLE;           // short frame dropped
          end else if (evt_i.bit_stb) begin
            shift_en_o = 1'b1;
            cnt_d      = cnt_q + 1'b1;
            if (cnt_q == SEG_LAST) state_d = ST_FULL;
          end
        end
        ST_FULL: begin
          if (evt_i.stop || evt_i.enb_cmt) begin
            commit_o = 1'b1;
            state_d  = ST_IDLE;
          end
        end
        ST_SKIP: begin
          if (evt_i.stop) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      addr_q  <= addr_d;
    end
  end

  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= SEG_FULL);

  a_r6_commit_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (cnt_q == SEG_FULL));

  a_r4_data_after_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && $past(state_q) == ST_ADDR) |-> $past(addr_hit));

  a_r5_no_shift_outside_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_o |-> (state_q == ST_DATA));

endmodule

// File: rtl/seg_payload.sv
module seg_payload #(
  parameter int SEG_W = 128,
  parameter int GRP   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_en_i,
  input  logic             shift_bit_i,
  input  logic             commit_i,
  output logic [SEG_W-1:0] seg_o,
  output logic             upd_o
);

  logic [SEG_W-1:0] shreg_q, mapped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         shreg_q <= '0;
    else if (shift_en_i) shreg_q <= {shreg_q[SEG_W-2:0], shift_bit_i};
  end

  // arrival k (oldest at MSB) -> group k/GRP, reversed inside the group
  for (genvar k = 0; k < SEG_W; k++) begin : g_map
    assign mapped[(k / GRP) * GRP + (GRP - 1 - (k % GRP))] = shreg_q[SEG_W-1-k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_o <= '0;
      upd_o <= 1'b0;
    end else begin
      upd_o <= commit_i;
      if (commit_i) seg_o <= mapped;
    end
  end

  a_r6_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o);

  a_r5_latch_only_on_upd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(seg_o) |-> upd_o);

endmodule

// File: rtl/seg_frame_rx.sv
module seg_frame_rx
  import seg_rx_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SEG_W       = 128,
  parameter int BP_N        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              sdat_i,
  input  logic              sclk_i,
  input  logic              senb_i,
  output logic [SEG_W-1:0]  seg_o,
  output logic              seg_upd_o
);

  pin_evt_t evt;
  logic     shift_en, shift_bit, commit;

  seg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sdat_i (sdat_i),
    .sclk_i (sclk_i),
    .senb_i (senb_i),
    .evt_o  (evt)
  );

  seg_frame_ctrl #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .dev_addr_i  (dev_addr_i),
    .shift_en_o  (shift_en),
    .shift_bit_o (shift_bit),
    .commit_o    (commit)
  );

  seg_payload #(.SEG_W(SEG_W), .GRP(BP_N)) u_payload (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_en_i  (shift_en),
    .shift_bit_i (shift_bit),
    .commit_i    (commit),
    .seg_o       (seg_o),
    .upd_o       (seg_upd_o)
  );

endmodule

// File: tb/seg_frame_rx_tb_top.sv
module seg_frame_rx_tb_top;

  localparam int SEG_W = 128;
  localparam int PH    = 4;
  localparam logic [7:0] MY_ADDR = 8'h5A;

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] seed;
    logic [1:0]  mode;   // 0 stop, 1 enable, 2 short+stop, 3 enable-low then stop
    logic        hit;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{8'h5A, 32'hDEADBEEF, 2'd0, 1'b1},
    '{8'h5A, 32'h12345678, 2'd1, 1'b1},
    '{8'h5B, 32'h0F0F0F0F, 2'd0, 1'b0},
    '{8'h5A, 32'hCAFEF00D, 2'd2, 1'b0},
    '{8'h5A, 32'h00000001, 2'd3, 1'b1},
    '{8'hA5, 32'hFFFFFFFF, 2'd1, 1'b0},
    '{8'h5A, 32'h80000000, 2'd0, 1'b1},
    '{8'hDA, 32'h13579BDF, 2'd0, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sdat = 1'b1, sclk = 1'b1, senb = 1'b0;
  logic [SEG_W-1:0] seg;
  logic             upd;
  int               n_chk = 0, n_err = 0, upd_cnt = 0;
  logic [SEG_W-1:0] exp_seg = '0;

  always #2.5ns clk = ~clk;

  seg_frame_rx dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .dev_addr_i (MY_ADDR),
    .sdat_i     (sdat),
    .sclk_i     (sclk),
    .senb_i     (senb),
    .seg_o      (seg),
    .seg_upd_o  (upd)
  );

  always @(posedge clk) if (rst_n && upd) upd_cnt++;

  task automatic chk(input string req, input logic [SEG_W-1:0] act, input logic [SEG_W-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic wph();
    repeat (PH) @(negedge clk);
  endtask

  task automatic s_start();
    sdat = 1'b1; wph();
    sclk = 1'b1; wph();
    sdat = 1'b0; wph();
    sclk = 1'b0; wph();
  endtask

  task automatic s_bit(input logic b);
    sdat = b;    wph();
    sclk = 1'b1; wph();
    sclk = 1'b0; wph();
  endtask

  task automatic s_stop();
    sclk = 1'b0; wph();
    sdat = 1'b0; wph();
    sclk = 1'b1; wph();
    sdat = 1'b1; wph();
  endtask

  task automatic s_enb_high();
    sclk = 1'b1; wph();
    senb = 1'b1; wph();
    senb = 1'b0; wph();
    sclk = 1'b0; wph();
  endtask

  task automatic s_enb_low();
    sclk = 1'b0; wph();
    senb = 1'b1; wph();
    senb = 1'b0; wph();
  endtask

  task automatic s_head(input logic [7:0] a, input logic [SEG_W-1:0] pat, input int nbits);
    s_start();
    for (int i = 7; i >= 0; i--) s_bit(a[i]);
    for (int k = 0; k < nbits; k++) s_bit(k < SEG_W ? pat[SEG_W-1-k] : 1'b1);
  endtask

  function automatic logic [SEG_W-1:0] mk_pat(input logic [31:0] s);
    return {s, ~s, s ^ 32'hA5A5A5A5, {s[15:0], s[31:16]}};
  endfunction

  function automatic logic [SEG_W-1:0] seg_map(input logic [SEG_W-1:0] pat);
    logic [SEG_W-1:0] r;
    r = '0;
    for (int k = 0; k < SEG_W; k++) r[4*(k/4) + 3 - (k%4)] = pat[SEG_W-1-k];
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 seg after reset", seg, '0);
    chk("R1 upd after reset", {127'd0, upd}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      logic [SEG_W-1:0] pat;
      int c0;
      pat = mk_pat(VEC[v].seed);
      c0  = upd_cnt;
      s_head(VEC[v].addr, pat, VEC[v].mode == 2'd2 ? 100 : SEG_W);
      case (VEC[v].mode)
        2'd1: begin
          s_enb_high();
          repeat (4) @(negedge clk);
          chk("R7 enable commit count", SEG_W'(upd_cnt - c0), SEG_W'(VEC[v].hit));
          s_stop();
        end
        2'd3: begin
          s_enb_low();
          repeat (4) @(negedge clk);
          chk("R8 enable while clock low ignored", SEG_W'(upd_cnt - c0), '0);
          s_stop();
        end
        default: s_stop();
      endcase
      repeat (4) @(negedge clk);
      if (VEC[v].hit) exp_seg = seg_map(pat);
      chk(VEC[v].mode == 2'd2 ? "R5 short frame dropped" :
          VEC[v].hit ? "R2 R3 R6 frame latched" : "R4 foreign address ignored",
          seg, exp_seg);
      chk("R6 single strobe count", SEG_W'(upd_cnt - c0), SEG_W'(VEC[v].hit));
    end

    // R3: lone first bit lands at segment 3
    s_head(MY_ADDR, {1'b1, 127'd0}, SEG_W);
    s_stop();
    repeat (4) @(negedge clk);
    exp_seg = 128'd8;
    chk("R3 first bit to frontplane 1 backplane 4", seg, exp_seg);

    // R9: three extra clocks after the payload are dropped
    begin
      logic [SEG_W-1:0] pat;
      pat = mk_pat(32'h3C3C1234);
      s_head(MY_ADDR, pat, SEG_W + 3);
      s_stop();
      repeat (4) @(negedge clk);
      exp_seg = seg_map(pat);
      chk("R9 overlong frame keeps first 128", seg, exp_seg);
    end

    // R10: restart mid payload
    begin
      logic [SEG_W-1:0] p1, p2;
      int c0;
      p1 = mk_pat(32'h0BADC0DE);
      p2 = mk_pat(32'h7E57AB1E);
      c0 = upd_cnt;
      s_head(MY_ADDR, p1, 50);
      s_head(MY_ADDR, p2, SEG_W);
      s_stop();
      repeat (4) @(negedge clk);
      exp_seg = seg_map(p2);
      chk("R10 restart takes second frame", seg, exp_seg);
      chk("R10 one strobe", SEG_W'(upd_cnt - c0), SEG_W'(1));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

endmodule